// File: doc/BRIEF.md
# Wave Execution-Mask Query Unit

This unit owns the execution mask of a 64-lane wave. It answers wave-wide questions about a per-lane predicate filtered through that mask. It can return the filtered predicate itself, say whether any or all of its lanes are set, count them, give every lane the number of set lanes below it for stream compaction, or broadcast the value held by the lowest active lane to every lane. The same unit also rewrites the mask for divergent branches: it can load it from a compare result, flip every bit, or restore it to all ones.

Each command enters through a valid/ready handshake together with a predicate vector and one 32-bit value per lane. The response comes back as a 64-bit scalar word and a 64×32 per-lane word vector, with a flag that marks a broadcast from an empty mask. Results pass through two register stages. A stalled output freezes the whole pipeline and blocks new commands. The live mask is also visible on its own port.

Top module: `wave_mask_unit`

## Requirements
- R1: While reset is asserted and after it is released, the mask reads all ones, `out_valid` is 0 and `in_ready` is 1.
- R2: Opcode 0 (ballot) returns `exec_mask & in_pred` on `out_scalar`, using the mask as it stood before that command's accepting edge.
- R3: Opcode 1 (any) returns 1 in bit 0 when the ballot is non-zero. Opcode 2 (all) returns 1 in bit 0 when the ballot has every bit set. All other scalar bits are 0.
- R4: Opcode 3 returns the number of set bits of the ballot on `out_scalar`.
- R5: Opcode 4 puts into per-lane word i the count of ballot bits set in lanes 0 to i-1, so lane 0 gets 0. It also returns the full count on `out_scalar`.
- R6: Opcode 5 takes the 32-bit value of the lowest-numbered lane whose mask bit is set. It drives that value into every per-lane word and into `out_scalar[31:0]`, with the upper scalar bits at 0 and `out_empty` at 0.
- R7: Opcode 5 with an all-zero mask returns lane 0's value and raises `out_empty`. `out_empty` is 0 for every other opcode.
- R8: Opcode 6 loads the mask from `in_pred`, opcode 7 inverts every mask bit and opcode 8 sets all mask bits to 1. The new mask shows on `exec_mask` right after the accepting edge and is returned on `out_scalar`.
- R9: `out_valid` rises on the second rising edge, counting the accepting edge as the first, provided `out_ready` stays high. A new command may be accepted on every cycle.
- R10: While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady and `in_ready` is 0. An offered command is not taken and leaves the mask unchanged.
- R11: Opcodes 9 to 15 return zero on every output word and leave the mask unchanged.
- R12: Per-lane words are 0 for every opcode other than 4 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Command can be taken this cycle |
| in_op | input | 4 | Opcode |
| in_pred | input | 64 | Per-lane predicate |
| in_vals | input | 2048 | Per-lane 32-bit values, lane i at bits [32i+31:32i] |
| exec_mask | output | 64 | Current execution mask |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_scalar | output | 64 | Scalar result |
| out_lanes | output | 2048 | Per-lane result words, lane i at bits [32i+31:32i] |
| out_empty | output | 1 | Broadcast was made from an empty mask |

## Verification
A command offered before edge E is taken at E. Its mask change is visible right after E, and its response is due right after the following edge. The bench drives on falling edges. Just after the accepting edge it checks that `out_valid` is still 0 and that the mask already holds its new value. One full cycle later it checks the response. A back-to-back pair confirms that responses keep coming one per cycle. During the stall test the bench samples once per cycle to confirm that the outputs hold and that the blocked command has no effect.

// File: rtl/wmq_pkg.sv
package wmq_pkg;
  typedef enum logic [3:0] {
    OP_BALLOT = 4'd0,
    OP_ANY    = 4'd1,
    OP_ALL    = 4'd2,
    OP_POPC   = 4'd3,
    OP_PREFIX = 4'd4,
    OP_FIRST  = 4'd5,
    OP_CMPW   = 4'd6,
    OP_INV    = 4'd7,
    OP_RESET  = 4'd8
  } wmq_op_e;
endpackage

// File: rtl/wmq_exec_mask.sv
module wmq_exec_mask
  import wmq_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [3:0]       op,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] mask_nxt
);
  function automatic logic [LANES-1:0] mask_after(input logic [3:0] o,
                                                  input logic [LANES-1:0] m,
                                                  input logic [LANES-1:0] p);
    case (o)
      OP_CMPW:  return p;
      OP_INV:   return ~m;
      OP_RESET: return '1;
      default:  return m;
    endcase
  endfunction

  assign mask_nxt = fire ? mask_after(op, mask_q, pred) : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_nxt;
  end

  // R8
  mask_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_INV |=> mask_q == ~$past(mask_q));
  // R8
  mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_RESET |=> mask_q == '1);
  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_CMPW |=> mask_q == $past(pred));
  // R10
  mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(mask_q));
  // R11
  mask_unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op > OP_RESET |=> $stable(mask_q));
endmodule

// File: rtl/wmq_first_lane.sv
module wmq_first_lane #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic [LANES-1:0]    mask,
  input  logic [LANES*DW-1:0] vals,
  output logic [DW-1:0]       first_val,
  output logic                empty
);
  localparam int IW = $clog2(LANES);

  function automatic logic [IW-1:0] lowest_set(input logic [LANES-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (m[i]) r = IW'(i);
    return r;
  endfunction

  logic [IW-1:0] idx;
  assign idx       = lowest_set(mask);
  assign empty     = (mask == '0);
  assign first_val = vals[idx*DW +: DW];
endmodule

// File: rtl/wmq_reduce.sv
module wmq_reduce #(
  parameter int LANES = 64,
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]    bal,
  output logic [CW-1:0]       total,
  output logic                any_set,
  output logic                all_set,
  output logic [LANES*CW-1:0] below
);
  function automatic logic [LANES*CW-1:0] running_counts(input logic [LANES-1:0] b);
    logic [LANES*CW-1:0] r;
    logic [CW-1:0]       c;
    c = '0;
    for (int i = 0; i < LANES; i++) begin
      r[i*CW +: CW] = c;
      c = c + CW'(b[i]);
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] ones(input logic [LANES-1:0] b);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < LANES; i++) c = c + CW'(b[i]);
    return c;
  endfunction

  assign below   = running_counts(bal);
  assign total   = ones(bal);
  assign any_set = |bal;
  assign all_set = &bal;
endmodule

// File: rtl/wave_mask_unit.sv
module wave_mask_unit
  import wmq_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [3:0]          in_op,
  input  logic [LANES-1:0]    in_pred,
  input  logic [LANES*DW-1:0] in_vals,
  output logic [LANES-1:0]    exec_mask,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES-1:0]    out_scalar,
  output logic [LANES*DW-1:0] out_lanes,
  output logic                out_empty
);
  localparam int CW = $clog2(LANES + 1);

  logic             advance, fire, in_mask_op;
  logic [LANES-1:0] mask_nxt;
  logic [DW-1:0]    sel_val;
  logic             sel_empty;

  logic             stage1_full;
  logic [3:0]       s1_op;
  logic [LANES-1:0] s1_bal;
  logic [DW-1:0]    s1_val;
  logic             s1_empty;
  logic [3:0]       out_op_q;

  logic [CW-1:0]       r_total;
  logic                r_any, r_all;
  logic [LANES*CW-1:0] r_below;

  logic [LANES-1:0]    nx_scalar;
  logic [LANES*DW-1:0] nx_lanes;
  logic                nx_empty;

  assign advance    = !out_valid || out_ready;
  assign in_ready   = advance;
  assign fire       = in_valid && advance;
  assign in_mask_op = (in_op == OP_CMPW) || (in_op == OP_INV) || (in_op == OP_RESET);

  wmq_exec_mask #(.LANES(LANES)) u_mask (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(in_op), .pred(in_pred),
    .mask_q(exec_mask), .mask_nxt(mask_nxt)
  );

  wmq_first_lane #(.LANES(LANES), .DW(DW)) u_first (
    .mask(exec_mask), .vals(in_vals), .first_val(sel_val), .empty(sel_empty)
  );

  wmq_reduce #(.LANES(LANES), .CW(CW)) u_reduce (
    .bal(s1_bal), .total(r_total), .any_set(r_any), .all_set(r_all), .below(r_below)
  );

  always_comb begin
    nx_scalar = '0;
    nx_lanes  = '0;
    nx_empty  = 1'b0;
    case (s1_op)
      OP_BALLOT, OP_CMPW, OP_INV, OP_RESET: nx_scalar = s1_bal;
      OP_ANY:  nx_scalar = LANES'(r_any);
      OP_ALL:  nx_scalar = LANES'(r_all);
      OP_POPC: nx_scalar = LANES'(r_total);
      OP_PREFIX: begin
        nx_scalar = LANES'(r_total);
        for (int i = 0; i < LANES; i++) nx_lanes[i*DW +: DW] = DW'(r_below[i*CW +: CW]);
      end
      OP_FIRST: begin
        nx_scalar = LANES'(s1_val);
        nx_empty  = s1_empty;
        for (int i = 0; i < LANES; i++) nx_lanes[i*DW +: DW] = s1_val;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_full <= 1'b0;
      s1_op       <= '0;
      s1_bal      <= '0;
      s1_val      <= '0;
      s1_empty    <= 1'b0;
      out_valid   <= 1'b0;
      out_op_q    <= '0;
      out_scalar  <= '0;
      out_lanes   <= '0;
      out_empty   <= 1'b0;
    end else if (advance) begin
      stage1_full <= fire;
      s1_op       <= in_op;
      s1_bal      <= in_mask_op ? mask_nxt : (exec_mask & in_pred);
      s1_val      <= sel_val;
      s1_empty    <= sel_empty;
      out_valid   <= stage1_full;
      out_op_q    <= s1_op;
      out_scalar  <= nx_scalar;
      out_lanes   <= nx_lanes;
      out_empty   <= nx_empty;
    end
  end

  // R9
  take_to_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> stage1_full);
  // R9
  stage1_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage1_full && advance |=> out_valid);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_scalar) && $stable(out_lanes)
                                && $stable(out_empty));
  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R7
  empty_only_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_empty |-> out_op_q == OP_FIRST);
  // R3
  flag_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_op_q == OP_ANY || out_op_q == OP_ALL) |-> out_scalar[LANES-1:1] == '0);
endmodule

// File: tb/tb_wave_mask_unit.sv
module tb_wave_mask_unit;
  localparam int L = 64;
  localparam int W = 32;
  localparam int NT = 21;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n, in_valid, in_ready, out_valid, out_ready, out_empty;
  logic [3:0]      in_op;
  logic [L-1:0]    in_pred, exec_mask, out_scalar;
  logic [L*W-1:0]  in_vals, out_lanes;

  wave_mask_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_pred(in_pred), .in_vals(in_vals), .exec_mask(exec_mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_scalar(out_scalar), .out_lanes(out_lanes), .out_empty(out_empty)
  );

  int checks = 0;
  int errors = 0;
  logic [L-1:0] model_mask;

  localparam logic [3:0] T_OP [NT] = '{
    4'd0, 4'd6, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd7, 4'd5, 4'd6,
    4'd5, 4'd1, 4'd8, 4'd2, 4'd3, 4'd4, 4'd6, 4'd5, 4'd15, 4'd0 };
  localparam logic [L-1:0] T_PRED [NT] = '{
    64'h00FF_00FF_00FF_00FF, 64'hF0F0_0000_0000_0F00, '1, 64'h000F_0000_0000_0000,
    '1, 64'hFFFF_FFFF_0000_FFFF, '1, 64'h0, 64'h0, 64'h0, 64'h0,
    64'h0, '1, 64'h0, '1, 64'h8000_0000_0000_0001, 64'hAAAA_AAAA_AAAA_AAAA,
    64'h8000_0000_0000_0000, 64'h0, '1, '1 };

  task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_lanes(input string req, input logic [L*W-1:0] act, input logic [L*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s lanes actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [L*W-1:0] make_vals(input int seed);
    logic [L*W-1:0] v;
    for (int i = 0; i < L; i++) v[i*W +: W] = 32'h5A00_0000 + 32'(seed) * 32'h1_0000 + 32'(i * 37 + 11);
    return v;
  endfunction

  function automatic int count_bits(input logic [L-1:0] x);
    int n = 0;
    logic [L-1:0] y = x;
    while (y != 0) begin
      y = y & (y - 1);
      n++;
    end
    return n;
  endfunction

  // Expected results from the requirements, written independently of the RTL
  task automatic expect_for(input logic [3:0] op, input logic [L-1:0] pred, input logic [L*W-1:0] v,
                            output logic [L-1:0] s, output logic [L*W-1:0] ln,
                            output logic e, output logic [L-1:0] nm);
    logic [L-1:0] b;
    int k;
    b  = model_mask & pred;
    s  = '0;
    ln = '0;
    e  = 1'b0;
    nm = model_mask;
    case (op)
      4'd0: s = b;
      4'd1: s = (b != 0) ? 64'd1 : 64'd0;
      4'd2: s = (b == '1) ? 64'd1 : 64'd0;
      4'd3: s = 64'(count_bits(b));
      4'd4: begin
        s = 64'(count_bits(b));
        for (int i = 0; i < L; i++) begin
          k = 0;
          for (int j = 0; j < i; j++) if (b[j]) k++;
          ln[i*W +: W] = 32'(k);
        end
      end
      4'd5: begin
        k = 0;
        while (k < L && !model_mask[k]) k++;
        if (k == L) begin
          k = 0;
          e = 1'b1;
        end
        s = 64'(v[k*W +: W]);
        for (int i = 0; i < L; i++) ln[i*W +: W] = v[k*W +: W];
      end
      4'd6: begin nm = pred;        s = nm; end
      4'd7: begin nm = ~model_mask; s = nm; end
      4'd8: begin nm = '1;          s = nm; end
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [3:0] op, input logic [L-1:0] pred, input int seed);
    logic [L-1:0] es, nm;
    logic [L*W-1:0] el, v;
    logic ee;
    v = make_vals(seed);
    expect_for(op, pred, v, es, el, ee, nm);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_pred = pred; in_vals = v;
    @(posedge clk);
    model_mask = nm;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 not yet valid", 64'(out_valid), 64'd0);
    chk("R8/R11 mask after accept", exec_mask, nm);
    @(posedge clk);
    @(negedge clk);
    chk("R9 valid on second edge", 64'(out_valid), 64'd1);
    if (op == 4'd0) chk("R2 ballot", out_scalar, es);
    else if (op == 4'd1 || op == 4'd2) chk("R3 any/all", out_scalar, es);
    else if (op == 4'd3) chk("R4 popcount", out_scalar, es);
    else if (op == 4'd4) chk("R5 prefix total", out_scalar, es);
    else if (op == 4'd5) chk("R6 first-lane scalar", out_scalar, es);
    else if (op >= 4'd6 && op <= 4'd8) chk("R8 new mask returned", out_scalar, es);
    else chk("R11 unused opcode scalar", out_scalar, es);
    if (op == 4'd4) chk_lanes("R5 prefix lanes", out_lanes, el);
    else if (op == 4'd5) chk_lanes("R6 broadcast lanes", out_lanes, el);
    else chk_lanes("R12 lanes zero", out_lanes, el);
    if (op == 4'd5 && ee) chk("R7 empty flag", 64'(out_empty), 64'd1);
    else chk("R7 empty flag low", 64'(out_empty), 64'd0);
  endtask

  bit done = 0;
  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] held, m0;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_pred = '0; in_vals = '0; out_ready = 1'b1;
    model_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 mask in reset", exec_mask, '1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mask after reset", exec_mask, '1);
    chk("R1 out_valid low", 64'(out_valid), 64'd0);
    chk("R1 in_ready high", 64'(in_ready), 64'd1);

    for (int t = 0; t < NT; t++) run_op(T_OP[t], T_PRED[t], t + 1);

    // R9: back-to-back commands give one response per cycle
    m0 = model_mask;
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'd7; in_pred = '0; in_vals = make_vals(40);
    @(negedge clk);
    in_op = 4'd0; in_pred = '1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 first of pair", out_scalar, ~m0);
    @(negedge clk);
    chk("R9 second of pair valid", 64'(out_valid), 64'd1);
    chk("R2 ballot sees mask from previous command", out_scalar, ~m0);
    model_mask = ~m0;

    // R10: stall holds outputs and blocks a command
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'd3; in_pred = 64'h0000_0000_0000_00FF;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    held = out_scalar;
    chk("R10 response present", 64'(out_valid), 64'd1);
    in_valid = 1'b1; in_op = 4'd7;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 in_ready low", 64'(in_ready), 64'd0);
      chk("R10 scalar held", out_scalar, held);
      chk("R10 blocked command leaves mask", exec_mask, model_mask);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", 64'(out_valid), 64'd0);
    chk("R10 mask still unchanged", exec_mask, model_mask);

    // R1: reset in mid-run restores the mask
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 mask restored", exec_mask, '1);
    chk("R1 output cleared", 64'(out_valid), 64'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule